// File: doc/BRIEF.md
# Bus-to-PCI Initiator Address Translator

This block sits between a local bus and a PCI initiator. For each local access it decides which window the address falls in, builds the matching 32-bit PCI address and 4-bit command code, and reports the result one cycle later. There are three windows. The memory window takes its upper address bits from a per-master mapping register. The lower half of an I/O bank becomes PCI I/O cycles, with the top 16 bits taken from an I/O mapping register. The upper half of the I/O bank becomes configuration cycles, addressed by a single set line-select bit.

A configuration access whose device field is zero is directed to the bridge's own configuration space. Such an access is reported on a separate pulse, so no external bus request results from it. It is also accepted while the master function is disabled, so that software can turn the master on. Any other access is refused with an error pulse when the master enable is clear, when a strap marks the bridge as sitting in a peripheral slot (configuration cycles only), when the device field selects a line bit beyond address bit 31, or when the address lies outside every window.

Requests arrive as a single-cycle `req_valid` pulse, and one request may arrive in every cycle. The block applies no back-pressure and has no ready signal. Exactly one of three result pulses follows each request in the next cycle, and whatever consumes the result must take it in that cycle. The mapping registers are written through a plain register port.

Top module: `pci_init_xlate`

## Requirements
- R1: Each request (`req_valid` high at a clock edge) produces exactly one of `out_valid`, `out_local`, `out_err`, high for one cycle and registered at that same edge. No result pulse appears in a cycle whose previous edge carried no request.
- R2: An address whose bits 31:28 equal 4'h8 is a memory access. The PCI address is {memory map of `req_mst`, address bits 27:0}, and the command is 4'b0110 for a read or 4'b0111 for a write.
- R3: Each of the 4 masters has its own 4-bit memory map register, selected by `req_mst`. Writing with `reg_sel` = m (0..3) loads `reg_wdata[31:28]` into master m's map. A request in the same cycle as the write still uses the old value, and a request in the next cycle uses the new value.
- R4: An address whose bits 31:17 equal 15'h7FFE and whose bit 16 is 0 is an I/O access. The PCI address is {I/O map, address bits 15:0}, and the command is 4'b0010 for a read or 4'b0011 for a write. Writing with `reg_sel` = 4 loads `reg_wdata[31:16]` into the I/O map.
- R5: An I/O-bank address with bit 16 set and a device field d = address bits 15:11 in the range 1..21 is an external configuration access. Its PCI address has only bit (d+10) set among bits 31:11, address bits 10:2 copied, and bits 1:0 zero. The command is 4'b1010 for a read or 4'b1011 for a write.
- R6: A configuration access with d = 0 produces `out_local` rather than `out_valid`. The address is {21'b0, address bits 10:2, 2'b00} with the configuration command. It is accepted whatever the values of `mst_en` and `periph_slot`.
- R7: While `mst_en` is 0, memory, I/O and external configuration accesses produce `out_err`.
- R8: While `periph_slot` is 1, external configuration accesses produce `out_err`. Memory and I/O accesses are unaffected.
- R9: Configuration accesses with d in 22..31, and addresses outside all windows, produce `out_err`.
- R10: After reset all result outputs are 0 and every mapping register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mst_en | input | 1 | Master function enable |
| periph_slot | input | 1 | Strap: bridge is in a peripheral slot |
| req_valid | input | 1 | Request pulse |
| req_addr | input | 32 | Local address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mst | input | 2 | Requesting master ID |
| reg_we | input | 1 | Mapping register write strobe |
| reg_sel | input | 3 | Register select: 0..3 memory maps, 4 I/O map |
| reg_wdata | input | 32 | Register write data |
| out_valid | output | 1 | Translated external request pulse |
| out_local | output | 1 | Own-configuration access pulse |
| out_err | output | 1 | Refused request pulse |
| out_addr | output | 32 | Translated PCI address |
| out_cmd | output | 4 | PCI command code |

## Verification
The bench sweeps all 32 device-field values for both directions under every combination of enable and slot strap. A design that computed the line-select bit off by one, or let devices 22..31 wrap into low address bits, would give wrong addresses. A design that gated own-configuration accesses by the enable would lock software out of the bridge. The bench also drives a map write and a request in the same cycle. This exposes a design that bypasses the new value into the current translation, or one that uses a different master's register. Bits 1:0 are driven high in configuration requests, and the bench checks that they come out as zero.

// File: rtl/pci_xl_pkg.sv
package pci_xl_pkg;
  localparam int PCI_AW       = 32;
  localparam int CFG_SEL_BASE = 10;
  localparam int CFG_DEV_MAX  = PCI_AW - 1 - CFG_SEL_BASE;

  typedef enum logic [3:0] {
    CMD_IO_RD  = 4'b0010,
    CMD_IO_WR  = 4'b0011,
    CMD_MEM_RD = 4'b0110,
    CMD_MEM_WR = 4'b0111,
    CMD_CFG_RD = 4'b1010,
    CMD_CFG_WR = 4'b1011
  } pci_cmd_e;

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_MEM,
    WIN_IO,
    WIN_CFG_EXT,
    WIN_CFG_OWN,
    WIN_CFG_BAD
  } win_e;

  typedef struct packed {
    logic [PCI_AW-1:0] addr;
    pci_cmd_e          cmd;
  } xl_req_t;
endpackage

// File: rtl/pci_xl_maps.sv
module pci_xl_maps #(
  parameter int NUM_MST   = 4,
  parameter int MEM_MAP_W = 4,
  parameter int IO_MAP_W  = 16,
  parameter int MST_W     = 2,
  parameter int SEL_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [SEL_W-1:0]     sel,
  input  logic [31:0]          wdata,
  input  logic [MST_W-1:0]     rd_id,
  output logic [MEM_MAP_W-1:0] mem_map,
  output logic [IO_MAP_W-1:0]  io_map
);
  localparam logic [SEL_W-1:0] IO_SEL = SEL_W'(NUM_MST);

  logic [NUM_MST-1:0][MEM_MAP_W-1:0] map_q;
  logic [IO_MAP_W-1:0]               io_q;

  // one map per master; only the selected entry changes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q <= '0;
      io_q  <= '0;
    end else if (we) begin
      for (int i = 0; i < NUM_MST; i++)
        if (sel == SEL_W'(i)) map_q[i] <= wdata[31 -: MEM_MAP_W];
      if (sel == IO_SEL) io_q <= wdata[31 -: IO_MAP_W];
    end
  end

  always_comb begin
    mem_map = '0;
    for (int i = 0; i < NUM_MST; i++)
      if (rd_id == MST_W'(i)) mem_map = map_q[i];
  end

  assign io_map = io_q;
endmodule

// File: rtl/pci_xl_decode.sv
module pci_xl_decode
  import pci_xl_pkg::*;
#(
  parameter int          MEM_LSB = 28,
  parameter logic [31:0] MEM_WIN = 32'h8,
  parameter logic [31:0] IO_BANK = 32'h7FFE
) (
  input  logic [31:0] addr,
  output win_e        win
);
  localparam int MW = 32 - MEM_LSB;

  logic [4:0] dev;
  assign dev = addr[15:11];

  always_comb begin
    if (addr[31:MEM_LSB] == MEM_WIN[MW-1:0])
      win = WIN_MEM;
    else if (addr[31:17] == IO_BANK[14:0]) begin
      if (!addr[16])                    win = WIN_IO;
      else if (dev == 5'd0)             win = WIN_CFG_OWN;
      else if (int'(dev) > CFG_DEV_MAX) win = WIN_CFG_BAD;
      else                              win = WIN_CFG_EXT;
    end else
      win = WIN_NONE;
  end
endmodule

// File: rtl/pci_xl_build.sv
module pci_xl_build
  import pci_xl_pkg::*;
#(
  parameter int MEM_LSB   = 28,
  parameter int MEM_MAP_W = 32 - MEM_LSB,
  parameter int IO_MAP_W  = 16
) (
  input  win_e                 win,
  input  logic [31:0]          addr,
  input  logic                 wr,
  input  logic [MEM_MAP_W-1:0] mem_map,
  input  logic [IO_MAP_W-1:0]  io_map,
  output xl_req_t              req
);
  logic [31:0] cfg_low;
  logic [31:0] cfg_line;

  assign cfg_low  = {21'b0, addr[10:2], 2'b00};
  assign cfg_line = 32'd1 << (6'(addr[15:11]) + 6'(CFG_SEL_BASE));

  always_comb begin
    req = '{addr: '0, cmd: CMD_MEM_RD};
    unique case (win)
      WIN_MEM: begin
        req.addr = {mem_map, addr[MEM_LSB-1:0]};
        req.cmd  = wr ? CMD_MEM_WR : CMD_MEM_RD;
      end
      WIN_IO: begin
        req.addr = {io_map, addr[31-IO_MAP_W:0]};
        req.cmd  = wr ? CMD_IO_WR : CMD_IO_RD;
      end
      WIN_CFG_EXT: begin
        req.addr = cfg_line | cfg_low;
        req.cmd  = wr ? CMD_CFG_WR : CMD_CFG_RD;
      end
      WIN_CFG_OWN: begin
        req.addr = cfg_low;
        req.cmd  = wr ? CMD_CFG_WR : CMD_CFG_RD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pci_init_xlate.sv
module pci_init_xlate
  import pci_xl_pkg::*;
#(
  parameter int          NUM_MST = 4,
  parameter int          MEM_LSB = 28,
  parameter logic [31:0] MEM_WIN = 32'h8,
  parameter logic [31:0] IO_BANK = 32'h7FFE,
  localparam int         MST_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1,
  localparam int         SEL_W   = $clog2(NUM_MST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mst_en,
  input  logic             periph_slot,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic             req_write,
  input  logic [MST_W-1:0] req_mst,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic             out_valid,
  output logic             out_local,
  output logic             out_err,
  output logic [31:0]      out_addr,
  output logic [3:0]       out_cmd
);
  localparam int MEM_MAP_W = 32 - MEM_LSB;
  localparam int IO_MAP_W  = 16;

  logic [MEM_MAP_W-1:0] mem_map;
  logic [IO_MAP_W-1:0]  io_map;
  win_e                 win;
  xl_req_t              built;
  logic                 accept;

  pci_xl_maps #(
    .NUM_MST(NUM_MST), .MEM_MAP_W(MEM_MAP_W), .IO_MAP_W(IO_MAP_W),
    .MST_W(MST_W), .SEL_W(SEL_W)
  ) u_maps (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .rd_id(req_mst), .mem_map(mem_map), .io_map(io_map)
  );

  pci_xl_decode #(.MEM_LSB(MEM_LSB), .MEM_WIN(MEM_WIN), .IO_BANK(IO_BANK)) u_dec (
    .addr(req_addr), .win(win)
  );

  pci_xl_build #(.MEM_LSB(MEM_LSB), .MEM_MAP_W(MEM_MAP_W), .IO_MAP_W(IO_MAP_W)) u_build (
    .win(win), .addr(req_addr), .wr(req_write),
    .mem_map(mem_map), .io_map(io_map), .req(built)
  );

  // refusal policy: own config always passes, external config also needs system slot
  always_comb begin
    unique case (win)
      WIN_MEM, WIN_IO: accept = mst_en;
      WIN_CFG_EXT:     accept = mst_en && !periph_slot;
      WIN_CFG_OWN:     accept = 1'b1;
      default:         accept = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_local <= 1'b0;
      out_err   <= 1'b0;
      out_addr  <= '0;
      out_cmd   <= '0;
    end else begin
      out_valid <= req_valid && accept && (win != WIN_CFG_OWN);
      out_local <= req_valid && (win == WIN_CFG_OWN);
      out_err   <= req_valid && !accept;
      if (req_valid) begin
        out_addr <= accept ? built.addr : '0;
        out_cmd  <= accept ? built.cmd  : 4'd0;
      end
    end
  end
endmodule

// File: rtl/pci_xl_check.sv
module pci_xl_check (
  input logic        clk,
  input logic        rst_n,
  input logic        mst_en,
  input logic        periph_slot,
  input logic        req_valid,
  input logic        out_valid,
  input logic        out_local,
  input logic        out_err,
  input logic [31:0] out_addr,
  input logic [3:0]  out_cmd
);
  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, out_local, out_err}));

  assert_resp_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_local || out_err) |-> $past(req_valid));

  assert_req_gets_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_valid || out_local || out_err));

  assert_cfg_line_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmd[3]) |-> ($countones(out_addr[31:11]) == 1 && out_addr[1:0] == 2'b00));

  assert_own_cfg_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_local |-> (out_addr[31:11] == 21'd0 && out_cmd[3]));

  assert_disabled_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(mst_en));

  assert_slot_blocks_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmd[3]) |-> !$past(periph_slot));
endmodule

bind pci_init_xlate pci_xl_check u_chk (
  .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .periph_slot(periph_slot),
  .req_valid(req_valid), .out_valid(out_valid), .out_local(out_local),
  .out_err(out_err), .out_addr(out_addr), .out_cmd(out_cmd)
);

// File: tb/test_pci_init_xlate.sv
module test_pci_init_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mst_en, periph_slot;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [1:0]  req_mst;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        out_valid, out_local, out_err;
  logic [31:0] out_addr;
  logic [3:0]  out_cmd;

  int tests = 0;
  int fails = 0;

  logic [3:0]  m_mem [4];
  logic [15:0] m_io;

  pci_init_xlate i_pci_init_xlate (
    .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .periph_slot(periph_slot),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_mst(req_mst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .out_valid(out_valid), .out_local(out_local), .out_err(out_err),
    .out_addr(out_addr), .out_cmd(out_cmd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // kind: 0 = out_valid, 1 = out_local, 2 = out_err
  task automatic model(input logic [31:0] a, input bit w, input int m, input bit en,
                       input bit slot, output int kind, output logic [31:0] ea,
                       output logic [3:0] ec);
    int dev;
    dev  = int'(a[15:11]);
    kind = 2; ea = 0; ec = 0;
    if (a[31:28] == 4'h8) begin
      kind = en ? 0 : 2;
      ea = {m_mem[m], a[27:0]};
      ec = w ? 4'b0111 : 4'b0110;
    end else if (a[31:17] == 15'h7FFE) begin
      if (!a[16]) begin
        kind = en ? 0 : 2;
        ea = {m_io, a[15:0]};
        ec = w ? 4'b0011 : 4'b0010;
      end else begin
        ec = w ? 4'b1011 : 4'b1010;
        if (dev == 0) begin
          kind = 1; ea = a & 32'h0000_07FC;
        end else if (dev > 21) kind = 2;
        else begin
          kind = (en && !slot) ? 0 : 2;
          ea = (32'd1 << (dev + 10)) | (a & 32'h0000_07FC);
        end
      end
    end
    if (kind == 2) begin ea = 0; ec = 0; end
  endtask

  task automatic write_reg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (sel < 3'd4) m_mem[sel] = d[31:28];
    else if (sel == 3'd4) m_io = d[31:16];
  endtask

  task automatic run_req(input logic [31:0] a, input bit w, input int m, input string req);
    int kind; logic [31:0] ea; logic [3:0] ec; logic [2:0] eflags;
    model(a, w, m, mst_en, periph_slot, kind, ea, ec);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_mst = 2'(m);
    @(negedge clk);
    req_valid = 1'b0;
    eflags = (kind == 0) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001;
    check({out_valid, out_local, out_err} == eflags, req, "outcome",
          64'({out_valid, out_local, out_err}), 64'(eflags));
    if (kind != 2) begin
      check(out_addr == ea, req, "addr", 64'(out_addr), 64'(ea));
      check(out_cmd == ec, req, "cmd", 64'(out_cmd), 64'(ec));
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    check({out_valid, out_local, out_err} == 3'b000, "R1", "idle pulse",
          64'({out_valid, out_local, out_err}), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    string tag;
    rst_n = 1'b0; mst_en = 1'b1; periph_slot = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_mst = '0;
    reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    for (int i = 0; i < 4; i++) m_mem[i] = '0;
    m_io = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check({out_valid, out_local, out_err, out_addr, out_cmd} == '0, "R10", "reset outputs",
          64'({out_valid, out_local, out_err}), 64'd0);
    run_req(32'h8ABC_DEF0, 1'b0, 2, "R10");
    run_req(32'hFFFC_1234, 1'b1, 0, "R10");
    idle_check();

    for (int m = 0; m < 4; m++) write_reg(3'(m), {4'(m * 3 + 5), 28'h0});
    write_reg(3'd4, 32'hA5C3_0000);

    // memory window sweep over masters, directions and offsets
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < 3; p++)
          run_req(32'h8000_0000 | (32'h0123_4567 * 32'(p + 1)) & 32'h0FFF_FFFF,
                  w[0], m, (p == 0) ? "R3" : "R2");

    // same-cycle write uses old map, next request sees new one
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd1; reg_wdata = 32'hE000_0000;
    req_valid = 1'b1; req_addr = 32'h8000_0040; req_write = 1'b0; req_mst = 2'd1;
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    check(out_valid && out_addr == {m_mem[1], 28'h000_0040}, "R3", "same-cycle old map",
          64'(out_addr), 64'({m_mem[1], 28'h000_0040}));
    m_mem[1] = 4'hE;
    run_req(32'h8000_0040, 1'b0, 1, "R3");
    idle_check();

    // I/O window
    for (int w = 0; w < 2; w++) begin
      run_req(32'hFFFC_0000, w[0], 0, "R4");
      run_req(32'hFFFC_FFFF, w[0], 3, "R4");
      run_req(32'hFFFC_5A3C, w[0], 2, "R4");
    end
    write_reg(3'd4, 32'h1357_FFFF);
    run_req(32'hFFFC_0F0F, 1'b1, 1, "R4");

    // configuration sweep: every device, direction, enable, slot
    for (int en = 0; en < 2; en++)
      for (int sl = 0; sl < 2; sl++) begin
        mst_en = en[0]; periph_slot = sl[0];
        for (int d = 0; d < 32; d++)
          for (int w = 0; w < 2; w++) begin
            if (d == 0) tag = "R6";
            else if (d > 21) tag = "R9";
            else if (en == 0) tag = "R7";
            else if (sl == 1) tag = "R8";
            else tag = "R5";
            run_req({15'h7FFE, 1'b1, 5'(d), 11'h5A7 ^ 11'(d * 37)} | 32'd3, w[0], 0, tag);
          end
      end

    // enable off / slot strap against memory and I/O
    mst_en = 1'b0; periph_slot = 1'b0;
    run_req(32'h8123_4567, 1'b0, 0, "R7");
    run_req(32'hFFFC_4321, 1'b1, 2, "R7");
    mst_en = 1'b1; periph_slot = 1'b1;
    run_req(32'h8765_4321, 1'b1, 3, "R8");
    run_req(32'hFFFC_8888, 1'b0, 1, "R8");
    periph_slot = 1'b0;

    // outside every window
    run_req(32'h1234_5678, 1'b0, 0, "R9");
    run_req(32'hFFFE_0000, 1'b1, 0, "R9");
    run_req(32'h7FFF_FFFF, 1'b0, 0, "R9");
    idle_check();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule